// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter in Transposed Form

This block filters a stream of signed 16-bit samples with three fixed signed 16-bit coefficients. Each incoming sample is broadcast to all three coefficient multipliers in the same cycle. There is no delay line on the input. The delay registers sit in the accumulation chain instead. The last tap's product is registered, added to the middle tap's product and registered again. The newest sample's product is then added to that partial sum to form the output. The result is numerically the same as a direct-form filter with the same coefficients.

Each multiplier is cut into two register-separated halves. The first half multiplies the low half of the sample by the coefficient. The second half multiplies the high half and merges the two partial products. The adder chain forms a third stage. No single stage holds more than one half-width multiply or one accumulation add. The block takes a new sample every clock and delivers a full-precision 34-bit result every clock.

Cycles in which the input is not marked valid push a zero sample into the filter. The output-valid flag follows the input-valid flag with the same delay as the data.

Top module: `fir3_bcast_pipe`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pipeline and partial-sum register is cleared. After the first such edge, `out_data` reads 0 and `out_valid` reads 0.
- R2: Let x(n) be the sample taken at the n-th rising edge. The output is then y(n) = H0·x(n) + H1·x(n−1) + H2·x(n−2), computed exactly in 34-bit two's complement with no rounding or truncation.
- R3: A sample taken at rising edge t appears in `out_data` after rising edge t+2. It is visible until edge t+3. `out_valid` after edge t+2 equals the `in_valid` taken at edge t.
- R4: A single non-zero sample surrounded by zeros yields H0·x, then H1·x, then H2·x on three consecutive outputs. This shows that the sample reaches all three multipliers at once.
- R5: A cycle with `in_valid` low enters a sample of value zero, whatever `in_data` holds. That zero still advances the filter history.
- R6: With all coefficients and all samples at −32768, the output reaches +3·2^30 without overflow.
- R7: A new sample is accepted on every clock with no stall. Back-to-back random samples each produce their own correct output, one per clock.
- R8: A reset in the middle of a stream discards all history. Outputs after the reset depend only on samples taken after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a real sample; when low a zero sample is entered |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | `in_valid` delayed by the pipeline latency |
| out_data | output | 34 | Signed full-precision filter output |

## Verification
An isolated impulse separates the three tap weights and pins the latency to a single cycle. A coefficient swapped between taps, or a register missing from the chain, therefore shows up at once. A long run of random back-to-back samples exercises both halves of each split multiplier with every sign combination. It exposes a wrong sign extension of the low partial product, or a wrong merge shift. Alternating valid and invalid cycles with non-zero data on the bus show whether a gap enters a zero or leaks the bus value. A second instance with the most negative coefficients, driven by the most negative sample, tests the top of the output range. A reset inside a live stream shows that no history survives.

// File: rtl/fir3_bcast_pipe.sv
module fir3_bcast_pipe #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 34,
  parameter logic signed [CW-1:0] H0 = 16'sd1234,
  parameter logic signed [CW-1:0] H1 = -16'sd2345,
  parameter logic signed [CW-1:0] H2 = 16'sd321
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  localparam int NT  = 3;
  localparam int LW  = DW / 2;
  localparam int HW  = DW - LW;
  localparam int PLW = LW + 1 + CW;
  localparam int PHW = HW + CW;

  logic signed [CW-1:0]  coef    [NT];
  logic signed [PLW-1:0] pl_next [NT];
  logic signed [PLW-1:0] pl_r    [NT];
  logic signed [AW-1:0]  m_next  [NT];
  logic signed [AW-1:0]  m_r     [NT];
  logic signed [DW-1:0]  xe;
  logic signed [HW-1:0]  xh_r;
  logic signed [AW-1:0]  s1_r, s2_r;
  logic [2:0]            v_r;
  logic [2:0]            cyc;

  assign coef[0] = H0;
  assign coef[1] = H1;
  assign coef[2] = H2;
  assign xe = in_valid ? in_data : '0;
  assign out_valid = v_r[2];

  for (genvar t = 0; t < NT; t++) begin : g_tap
    logic signed [PHW-1:0] ph;
    logic signed [AW-1:0]  hi_ext, lo_ext;
    assign pl_next[t] = $signed({1'b0, xe[LW-1:0]}) * coef[t];
    assign ph         = xh_r * coef[t];
    assign hi_ext     = {{(AW-PHW){ph[PHW-1]}}, ph};
    assign lo_ext     = {{(AW-PLW){pl_r[t][PLW-1]}}, pl_r[t]};
    assign m_next[t]  = (hi_ext <<< LW) + lo_ext;

    // Each product register equals the exact product of the sample two edges back
    assert_tap_product_R2: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd2) |-> (m_r[t] == $past(xe, 2) * coef[t]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xh_r     <= '0;
      s1_r     <= '0;
      s2_r     <= '0;
      out_data <= '0;
      v_r      <= '0;
      for (int t = 0; t < NT; t++) begin
        pl_r[t] <= '0;
        m_r[t]  <= '0;
      end
    end else begin
      xh_r     <= xe[DW-1:LW];
      s2_r     <= m_r[2];
      s1_r     <= m_r[1] + s2_r;
      out_data <= m_r[0] + s1_r;
      v_r      <= {v_r[1:0], in_valid};
      for (int t = 0; t < NT; t++) begin
        pl_r[t] <= pl_next[t];
        m_r[t]  <= m_next[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_data == '0 && !out_valid));

  assert_valid_lag_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_full_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd5) |-> (out_data == $past(xe, 3) * H0 + $past(xe, 4) * H1 + $past(xe, 5) * H2));
endmodule

// File: tb/fir3_bcast_pipe_test.sv
module fir3_bcast_pipe_test;
  localparam logic signed [15:0] C0 = 16'sd1234;
  localparam logic signed [15:0] C1 = -16'sd2345;
  localparam logic signed [15:0] C2 = 16'sd321;
  localparam logic signed [15:0] MN = -16'sd32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid, out_valid_m;
  logic signed [33:0] out_data, out_data_m;

  int checks = 0;
  int failures = 0;
  int idx = 0;
  logic signed [15:0] hx [0:511];
  logic hv [0:511];

  always #5 clk = ~clk;

  fir3_bcast_pipe #(.H0(C0), .H1(C1), .H2(C2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  fir3_bcast_pipe #(.H0(MN), .H1(MN), .H2(MN)) uut_max (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_m), .out_data(out_data_m));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint xat(input int m);
    return (m < 0) ? 64'sd0 : longint'(hx[m]);
  endfunction

  function automatic longint model(input int n, input longint a, input longint b, input longint c);
    return a * xat(n) + b * xat(n - 1) + c * xat(n - 2);
  endfunction

  // Called at a falling edge: checks the output due now, then drives the next sample
  task automatic step(input logic v, input logic signed [15:0] d, input string tag);
    int n;
    n = idx - 3;
    check({tag, " data"}, longint'(out_data), model(n, C0, C1, C2));
    check({tag, " max-data"}, longint'(out_data_m), model(n, MN, MN, MN));
    check({tag, " valid"}, longint'(out_valid), (n >= 0 && hv[n]) ? 64'sd1 : 64'sd0);
    in_valid = v;
    in_data  = d;
    hx[idx]  = v ? d : 16'sd0;
    hv[idx]  = v;
    idx++;
    @(negedge clk);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 4; i++) step(1'b0, 16'sd0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    @(negedge clk);
    check("R1 reset data", longint'(out_data), 0);
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset max-data", longint'(out_data_m), 0);
    @(negedge clk);
    rst = 1'b0;
    idx = 0;
  endtask

  task automatic t_impulse();
    step(1'b1, 16'sd100, "R4 impulse");
    for (int i = 0; i < 5; i++) step(1'b1, 16'sd0, "R3 R4 impulse");
    step(1'b1, -16'sd7, "R4 negative impulse");
    flush("R3 impulse tail");
  endtask

  task automatic t_random();
    for (int i = 0; i < 80; i++) step(1'b1, 16'($urandom()), "R2 R7 random");
    flush("R2 random tail");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 24; i++)
      step((i % 3) != 1, 16'sd20000 - 16'(i * 517), "R5 gaps");
    for (int i = 0; i < 6; i++) step(1'b0, -16'sd12345, "R5 invalid bus");
    flush("R5 tail");
  endtask

  task automatic t_extreme();
    for (int i = 0; i < 6; i++) step(1'b1, MN, "R6 min");
    for (int i = 0; i < 6; i++) step(1'b1, (i % 2) ? 16'sd32767 : MN, "R6 alternate");
    flush("R6 tail");
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 5; i++) step(1'b1, 16'sd9000 + 16'(i), "R8 before");
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, -16'sd300 + 16'(i * 97), "R8 after");
    flush("R8 tail");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    t_impulse();
    t_random();
    t_gaps();
    t_extreme();
    t_midreset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule